// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

This block is a synchronous binary up counter built from identical narrow stages. Each stage has a clear input, a parallel load, two count enables and a terminal-count output. Within each stage the clear wins over the load, and the load wins over counting. A stage advances only when both of its enables are high. Its terminal count is high when the stage holds the all-ones value and its trickle enable is high. The parallel enable has no effect on the terminal count.

The top level chains `NUM_STAGES` stages of `STAGE_W` bits. One shared enable drives every parallel enable. The first trickle enable comes from a port, and each later trickle enable is the terminal count of the stage before it. The chain therefore behaves as one counter of `STAGE_W*NUM_STAGES` bits, and its final terminal count can feed a further chain. A parameter selects one of two clear variants. In the first, the clear acts on the rising clock edge. In the second, it clears the state as soon as it goes low, with no clock edge needed.

Top module: `cnt_chain`

## Requirements
- R1: With `ASYNC_CLR=0`, `rst_ni` low at a rising edge sets `q_o` to zero on that edge. This overrides load and count, and `q_o` does not change between edges.
- R2: With `ASYNC_CLR=1`, `q_o` becomes zero as soon as `rst_ni` goes low, before any clock edge, and stays zero while `rst_ni` is low.
- R3: With `rst_ni` high, `load_ni` low at a rising edge copies `data_i` into `q_o`, whatever the enables are.
- R4: With `rst_ni` and `load_ni` high and both `cnt_en_i` and `carry_en_i` high, each rising edge adds one to `q_o`.
- R5: With `rst_ni` and `load_ni` high and either `cnt_en_i` or `carry_en_i` low, `q_o` holds its value.
- R6: Counting from the all-ones value wraps `q_o` to zero.
- R7: `tc_o` is combinational. It is 1 exactly when `q_o` is all ones and `carry_en_i` is 1, and it does not depend on `cnt_en_i`.
- R8: A carry out of a lower stage advances the next stage on the same edge. For example, with the default widths, `8'h0F` counts to `8'h10` and `8'hFF` counts to `8'h00`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all state changes on its rising edge (except the asynchronous clear) |
| rst_ni | input | 1 | Active-low clear, synchronous or asynchronous per `ASYNC_CLR` |
| load_ni | input | 1 | Active-low parallel load |
| data_i | input | STAGE_W*NUM_STAGES | Parallel load value |
| cnt_en_i | input | 1 | Parallel count enable shared by all stages |
| carry_en_i | input | 1 | Trickle enable into the lowest stage |
| q_o | output | STAGE_W*NUM_STAGES | Counter state |
| tc_o | output | 1 | Terminal count of the top stage |

## Verification
Several controls can be active in the same cycle, and only one of them should take effect. Clear can coincide with load, load can coincide with an enabled count, and a count can coincide with the all-ones wrap while the terminal count is high. The bench drives all sixteen settings of clear, load and the two enables from a known preload. Each result is judged against a model that applies the stated precedence. Clear is also pulled low between edges on both variants, and the asynchronous instance must show zero at once while the synchronous one keeps its value until the edge.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD  = 2'd0,
    MODE_COUNT = 2'd1,
    MODE_LOAD  = 2'd2,
    MODE_CLEAR = 2'd3
  } cnt_mode_e;

  // priority: clear > load > count > hold
  function automatic cnt_mode_e pick_mode(logic clr_n, logic load_n, logic cep, logic cet);
    if (!clr_n)          return MODE_CLEAR;
    else if (!load_n)    return MODE_LOAD;
    else if (cep && cet) return MODE_COUNT;
    else                 return MODE_HOLD;
  endfunction
endpackage

// File: rtl/cnt_mode_dec.sv
module cnt_mode_dec
  import cnt_pkg::*;
(
  input  logic      clr_ni,
  input  logic      load_ni,
  input  logic      cep_i,
  input  logic      cet_i,
  output cnt_mode_e mode_o
);
  always_comb mode_o = pick_mode(clr_ni, load_ni, cep_i, cet_i);
endmodule

// File: rtl/cnt_stage.sv
module cnt_stage
  import cnt_pkg::*;
#(
  parameter int unsigned W         = 4,
  parameter bit          ASYNC_CLR = 1'b0
) (
  input  logic         clk_i,
  input  logic         clr_ni,
  input  logic         load_ni,
  input  logic [W-1:0] data_i,
  input  logic         cep_i,
  input  logic         cet_i,
  output logic [W-1:0] q_o,
  output logic         tc_o
);
  localparam logic [W-1:0] ALL_ONES = '1;

  cnt_mode_e    mode;
  logic [W-1:0] q_q, q_d;

  cnt_mode_dec u_dec (
    .clr_ni (clr_ni),
    .load_ni(load_ni),
    .cep_i  (cep_i),
    .cet_i  (cet_i),
    .mode_o (mode)
  );

  always_comb begin
    unique case (mode)
      MODE_CLEAR: q_d = '0;
      MODE_LOAD:  q_d = data_i;
      MODE_COUNT: q_d = q_q + W'(1);
      default:    q_d = q_q;
    endcase
  end

  generate
    if (ASYNC_CLR) begin : g_async
      always_ff @(posedge clk_i or negedge clr_ni) begin
        if (!clr_ni) q_q <= '0;
        else         q_q <= q_d;
      end
    end else begin : g_sync
      always_ff @(posedge clk_i) q_q <= q_d;
    end
  endgenerate

  assign q_o  = q_q;
  // trickle enable only; parallel enable deliberately excluded
  assign tc_o = (q_q == ALL_ONES) && cet_i;
endmodule

// File: rtl/cnt_chain.sv
module cnt_chain #(
  parameter int unsigned STAGE_W    = 4,
  parameter int unsigned NUM_STAGES = 2,
  parameter bit          ASYNC_CLR  = 1'b0,
  localparam int unsigned TOTAL_W   = STAGE_W * NUM_STAGES
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_ni,
  input  logic [TOTAL_W-1:0] data_i,
  input  logic               cnt_en_i,
  input  logic               carry_en_i,
  output logic [TOTAL_W-1:0] q_o,
  output logic               tc_o
);
  logic [NUM_STAGES:0] carry;

  assign carry[0] = carry_en_i;

  for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
    cnt_stage #(
      .W        (STAGE_W),
      .ASYNC_CLR(ASYNC_CLR)
    ) u_stage (
      .clk_i  (clk_i),
      .clr_ni (rst_ni),
      .load_ni(load_ni),
      .data_i (data_i[s*STAGE_W +: STAGE_W]),
      .cep_i  (cnt_en_i),
      .cet_i  (carry[s]),
      .q_o    (q_o[s*STAGE_W +: STAGE_W]),
      .tc_o   (carry[s+1])
    );
  end

  assign tc_o = carry[NUM_STAGES];
endmodule

// File: rtl/cnt_chain_chk.sv
module cnt_chain_chk #(
  parameter int unsigned W         = 8,
  parameter bit          ASYNC_CLR = 1'b0
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         load_ni,
  input logic [W-1:0] data_i,
  input logic         cnt_en_i,
  input logic         carry_en_i,
  input logic [W-1:0] q_o,
  input logic         tc_o
);
  AST_CLEAR_EDGE: assert property (@(posedge clk_i)
    !rst_ni |=> (q_o == '0)); // R1

  generate
    if (ASYNC_CLR) begin : g_async_chk
      AST_CLEAR_HELD: assert property (@(posedge clk_i)
        !rst_ni |-> (q_o == '0)); // R2
    end
  endgenerate

  AST_LOAD_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_ni |=> (q_o == $past(data_i))); // R3

  AST_COUNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && cnt_en_i && carry_en_i) |=> (q_o == ($past(q_o) + W'(1)))); // R4

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && !(cnt_en_i && carry_en_i)) |=> $stable(q_o)); // R5

  AST_WRAP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && cnt_en_i && carry_en_i && (&q_o)) |=> (q_o == '0)); // R6

  AST_TC_DECODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o == ((&q_o) && carry_en_i)); // R7
endmodule

bind cnt_chain cnt_chain_chk #(
  .W        (TOTAL_W),
  .ASYNC_CLR(ASYNC_CLR)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .load_ni   (load_ni),
  .data_i    (data_i),
  .cnt_en_i  (cnt_en_i),
  .carry_en_i(carry_en_i),
  .q_o       (q_o),
  .tc_o      (tc_o)
);

// File: tb/cnt_chain_tb_top.sv
module cnt_chain_tb_top;
  localparam int SW = 4;
  localparam int NS = 2;
  localparam int W  = SW * NS;
  localparam logic [W-1:0] ALL = '1;

  logic clk_i = 1'b0;
  always #5 clk_i = ~clk_i;

  logic         rst_n = 1'b0, ld_n = 1'b1, cep = 1'b0, cet = 1'b0;
  logic [W-1:0] d = '0;
  logic [W-1:0] q_s, q_a;
  logic         tc_s, tc_a;

  cnt_chain #(.STAGE_W(SW), .NUM_STAGES(NS), .ASYNC_CLR(1'b0)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_n), .load_ni(ld_n), .data_i(d),
    .cnt_en_i(cep), .carry_en_i(cet), .q_o(q_s), .tc_o(tc_s));

  cnt_chain #(.STAGE_W(SW), .NUM_STAGES(NS), .ASYNC_CLR(1'b1)) dut_a_i (
    .clk_i(clk_i), .rst_ni(rst_n), .load_ni(ld_n), .data_i(d),
    .cnt_en_i(cep), .carry_en_i(cet), .q_o(q_a), .tc_o(tc_a));

  int n_chk = 0, n_fail = 0;
  logic [W-1:0] m_s = '0, m_a = '0;
  bit s_known = 1'b0;
  logic [W-1:0] exp_s_q[$], exp_a_q[$];
  string tag_q[$];

  function automatic void chk(bit ok, string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endfunction

  function automatic logic [W-1:0] model_nxt(logic [W-1:0] m, logic c, logic l, logic [W-1:0] dv, logic p, logic t);
    if (!c)         return '0;
    else if (!l)    return dv;
    else if (p && t) return m + W'(1);
    else            return m;
  endfunction

  function automatic string tag_of(logic c, logic l, logic p, logic t, logic [W-1:0] m);
    if (!c)      return "R1";
    if (!l)      return "R3";
    if (p && t)  return (m == ALL) ? "R6" : (m[SW-1:0] == '1) ? "R8" : "R4";
    return "R5";
  endfunction

  // driver: apply between edges, check combinational outputs, push expected state
  task automatic drive(input logic c, input logic l, input logic [W-1:0] dv, input logic p, input logic t);
    string tg;
    @(negedge clk_i);
    rst_n = c; ld_n = l; d = dv; cep = p; cet = t;
    #1;
    tg = tag_of(c, l, p, t, m_a);
    if (!c) begin
      m_a = '0;
      chk(q_a === '0, "R2", "async q before edge", q_a, '0);
      if (s_known) chk(q_s === m_s, "R1", "sync q before edge", q_s, m_s);
    end
    chk(tc_a === ((m_a == ALL) && t), "R7", "async tc", W'(tc_a), W'((m_a == ALL) && t));
    if (s_known) chk(tc_s === ((m_s == ALL) && t), "R7", "sync tc", W'(tc_s), W'((m_s == ALL) && t));
    m_s = model_nxt(m_s, c, l, dv, p, t);
    m_a = model_nxt(m_a, c, l, dv, p, t);
    if (!c) s_known = 1'b1;
    if (s_known) begin
      exp_s_q.push_back(m_s);
      exp_a_q.push_back(m_a);
      tag_q.push_back(tg);
    end
  endtask

  // monitor: compare state after each edge
  initial begin
    forever begin
      @(posedge clk_i);
      #2;
      if (exp_s_q.size() > 0) begin
        logic [W-1:0] es, ea;
        string tg;
        es = exp_s_q.pop_front();
        ea = exp_a_q.pop_front();
        tg = tag_q.pop_front();
        chk(q_s === es, tg, "sync q", q_s, es);
        chk(q_a === ea, tg, "async q", q_a, ea);
      end
    end
  end

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired act=%0d exp=0", n_chk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    // reset state R1 R2
    drive(1'b0, 1'b1, '0, 1'b1, 1'b1);
    drive(1'b0, 1'b0, 8'h5A, 1'b1, 1'b1);
    // plain counting across stage boundary R4 R8
    for (int i = 0; i < 20; i++) drive(1'b1, 1'b1, '0, 1'b1, 1'b1);
    // load then carry into upper stage R3 R8
    drive(1'b1, 1'b0, 8'h0F, 1'b1, 1'b1);
    drive(1'b1, 1'b1, '0, 1'b1, 1'b1);
    // every precedence setting from a known preload R1 R3 R4 R5
    for (int k = 0; k < 16; k++) begin
      drive(1'b1, 1'b0, 8'h3C, 1'b0, 1'b0);
      drive(k[3], k[2], 8'hA5, k[1], k[0]);
      drive(1'b1, 1'b1, '0, 1'b0, 1'b0);
    end
    // all ones: tc ignores parallel enable, then wrap R6 R7
    drive(1'b1, 1'b0, ALL, 1'b0, 1'b0);
    drive(1'b1, 1'b1, '0, 1'b0, 1'b1);
    drive(1'b1, 1'b1, '0, 1'b1, 1'b0);
    drive(1'b1, 1'b1, '0, 1'b1, 1'b1);
    drive(1'b1, 1'b1, '0, 1'b1, 1'b1);
    // lower stage all ones only: no tc R7
    drive(1'b1, 1'b0, 8'h0F, 1'b1, 1'b1);
    drive(1'b1, 1'b1, '0, 1'b0, 1'b1);
    // clear between edges mid-count R2 R1
    drive(1'b1, 1'b0, 8'h77, 1'b1, 1'b1);
    drive(1'b0, 1'b1, '0, 1'b1, 1'b1);
    drive(1'b1, 1'b1, '0, 1'b1, 1'b1);
    // mixed traffic
    for (int i = 0; i < 400; i++)
      drive(($urandom % 16) != 0, ($urandom % 8) != 0, W'($urandom),
            ($urandom % 4) != 0, ($urandom % 4) != 0);
    drive(1'b1, 1'b1, '0, 1'b0, 1'b0);
    repeat (3) @(posedge clk_i);
    #3;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule